// File: doc/BRIEF.md
# EPROM Word Programming Sequencer

This block runs the write flow for a 16-bit-wide UV-erasable memory chip, one word at a time, over a host-chosen address range. For each word it takes a source word from the host, drives address and data with the required setup spacing, fires program strobes and reads the word back after each one. It keeps firing until the readback matches or a try limit runs out. It also raises the two supply-level request flags in the safe order and drops them when the range is done or aborted. The external supply circuit acts on these flags.

Two pulse algorithms are selectable per job. The short one repeats a 100 µs strobe until the word verifies. The long one repeats a 1 ms strobe, and after a word verifies on try X it adds one more strobe of 3·X ms. After the last word both supply requests drop, and every word is read again at normal levels and compared with the source words, which the host serves a second time. The job ends with done plus exactly one of pass or fail. On fail, the address that failed is reported.

All durations are counted in clock cycles derived from a clock-frequency parameter.

Top module: `eprom_prog_seq`

## Requirements
- R1: After a synchronous active-low reset: dev_ce_n, dev_oe_n and dev_pgm_n are 1, vcc_hi_req, vpp_hi_req, src_req, done, pass and fail are 0, and the controller does not drive dev_data.
- R2: vpp_hi_req is never 1 while vcc_hi_req is 0. vcc_hi_req rises at least T_SETUP_US before vpp_hi_req. vpp_hi_req has been 1 for at least T_SETUP_US before any program strobe begins.
- R3: A program strobe is dev_pgm_n = 0 with dev_ce_n = 0 and dev_oe_n = 1. Address, driven data and dev_oe_n = 1 are steady for at least T_SETUP_US before it. Address and data stay steady during it, and the data stays driven for at least T_HOLD_US after it.
- R4: With algo_long = 0, each strobe lasts T_SHORT_US. A verify read follows every strobe, and a word receives strobes until its readback equals the source word.
- R5: With algo_long = 1, each try strobe lasts T_LONG_US. When the word verifies after X strobes, exactly one further strobe of 3·X·T_LONG_US is applied, and then the address advances.
- R6: A verify or compare read holds dev_ce_n = 0, dev_oe_n = 0 and dev_pgm_n = 1. The controller never drives dev_data while dev_oe_n = 0.
- R7: If a word still mismatches after the try limit (MAX_TRY_SHORT or MAX_TRY_LONG strobes), no further strobe is issued. The job ends with fail = 1, fail_addr = that address, and both supply requests low.
- R8: A source word is requested by holding src_req = 1 while dev_addr shows that word's address. The controller takes src_data in the cycle src_ack = 1 and drops src_req after that cycle.
- R9: After the last address, both supply requests drop. Every address from start_addr to end_addr is then fetched again and read back. The first mismatch ends the job with fail and fail_addr; if all words match, the job ends with pass.
- R10: At the end of a job, done = 1 with exactly one of pass and fail. These outputs hold until the next start.
- R11: Programming only clears bits. A source word that needs a 0 cell to become 1 never verifies and ends under R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job (sampled when idle) |
| algo_long | input | 1 | 0 = short-pulse algorithm, 1 = long-pulse with overprogram |
| start_addr | input | ADDR_W | First address of the range |
| end_addr | input | ADDR_W | Last address of the range |
| src_req | output | 1 | Request for the source word at dev_addr |
| src_ack | input | 1 | One-cycle acknowledge, src_data valid |
| src_data | input | DATA_W | Source word |
| done | output | 1 | Job finished |
| pass | output | 1 | Job finished with all words matching |
| fail | output | 1 | Job aborted or compare mismatch |
| fail_addr | output | ADDR_W | Address that caused the failure |
| dev_addr | output | ADDR_W | Memory address |
| dev_data | inout | DATA_W | Memory data bus |
| dev_ce_n | output | 1 | Chip enable, active low |
| dev_oe_n | output | 1 | Output enable, active low |
| dev_pgm_n | output | 1 | Program strobe, active low |
| vcc_hi_req | output | 1 | Request main supply at programming level |
| vpp_hi_req | output | 1 | Request programming supply at high level |

## Verification
The bench builds the block with CLK_HZ = 1 MHz, so one microsecond is one cycle. This makes the strobe lengths directly countable: 100 cycles for a short strobe, 1000 for a long one, and 3000·X for an overprogram strobe. The try limits are lowered to 4 (short) and 3 (long), which brings both abort paths within a few thousand cycles. The memory model needs a chosen number of strobes per word. Together with a pre-cleared cell and a bit flip injected when the programming supply drops, this reaches retry counts, the one-way-bits abort and compare-pass failures.

// File: rtl/eps_pkg.sv
// Shared types for the EPROM programming sequencer.
// Assumes: none beyond a synthesizable enum.
package eps_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_VCC, ST_VPP, ST_FETCH, ST_SETUP, ST_PULSE, ST_HOLD,
        ST_VERIFY, ST_SETTLE, ST_CFETCH, ST_CREAD, ST_FINISH
    } eps_state_t;
endpackage

// File: rtl/eps_timer.sv
// Down-counter that times each sequencer phase.
// Loading val makes zero rise after val further cycles, so a phase that
// loads N-1 on entry lasts N cycles. Assumes load is only asserted on phase entry.
module eps_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/eps_addr_walk.sv
// Address walker over an inclusive range [first, final].
// Assumes first <= final. A rewind returns to first for the compare pass.
module eps_addr_walk #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] first,
    input  logic [AW-1:0] final_a,
    input  logic          rewind,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [AW-1:0] lo_q, hi_q;

    // Latch range on load, restart on rewind, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0; hi_q <= '0; addr <= '0;
        end else if (load) begin
            lo_q <= first; hi_q <= final_a; addr <= first;
        end else if (rewind) begin
            addr <= lo_q;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end

    assign last = (addr == hi_q);
endmodule

// File: rtl/eps_bus_drv.sv
// Tri-state driver for the bidirectional memory data bus.
// Assumes the enable is registered and low whenever the memory may drive.
module eps_bus_drv #(
    parameter int DW = 16
) (
    input  logic          en,
    input  logic [DW-1:0] dout,
    output logic [DW-1:0] din,
    inout  wire  [DW-1:0] bus
);
    assign bus = en ? dout : 'z;
    assign din = bus;
endmodule

// File: rtl/eprom_prog_seq.sv
// Word-by-word program/verify sequencer for a 16-bit UV-erasable memory.
// Raises supply requests in order, fetches each source word, strobes it in
// with setup/hold spacing, verifies and retries up to a limit, optionally
// overprograms, then re-reads all words at normal levels.
// Assumes: start_addr <= end_addr; CLK_HZ is a whole multiple of 1 MHz.
module eprom_prog_seq
    import eps_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 16,
    parameter int CLK_HZ        = 50_000_000,
    parameter int T_SETUP_US    = 2,
    parameter int T_HOLD_US     = 2,
    parameter int T_READ_US     = 1,
    parameter int T_SHORT_US    = 100,
    parameter int T_LONG_US     = 1000,
    parameter int MAX_TRY_SHORT = 25,
    parameter int MAX_TRY_LONG  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              algo_long,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              src_req,
    input  logic              src_ack,
    input  logic [DATA_W-1:0] src_data,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ADDR_W-1:0] dev_addr,
    inout  wire  [DATA_W-1:0] dev_data,
    output logic              dev_ce_n,
    output logic              dev_oe_n,
    output logic              dev_pgm_n,
    output logic              vcc_hi_req,
    output logic              vpp_hi_req
);
    localparam int US_CYC    = CLK_HZ / 1_000_000;
    localparam int SETUP_CYC = T_SETUP_US * US_CYC;
    localparam int HOLD_CYC  = T_HOLD_US * US_CYC;
    localparam int READ_CYC  = T_READ_US * US_CYC;
    localparam int SHORT_CYC = T_SHORT_US * US_CYC;
    localparam int LONG_CYC  = T_LONG_US * US_CYC;
    localparam int MAX_TRY   = (MAX_TRY_SHORT > MAX_TRY_LONG) ? MAX_TRY_SHORT : MAX_TRY_LONG;
    localparam int TRY_W     = $clog2(MAX_TRY + 1);
    localparam int TIM_W     = 32;

    eps_state_t         st, nxt;
    logic [DATA_W-1:0]  word, din;
    logic [TRY_W-1:0]   tries, lim;
    logic               over, long_m, drive_en, tm_zero, tm_load, last, match;
    logic [TIM_W-1:0]   len, tm_val;

    assign lim     = long_m ? TRY_W'(MAX_TRY_LONG) : TRY_W'(MAX_TRY_SHORT);
    assign match   = (din == word);
    assign src_req = (st == ST_FETCH) || (st == ST_CFETCH);

    // Next-phase decision.
    always_comb begin
        nxt = st;
        case (st)
            ST_IDLE:   if (start)    nxt = ST_VCC;
            ST_VCC:    if (tm_zero)  nxt = ST_VPP;
            ST_VPP:    if (tm_zero)  nxt = ST_FETCH;
            ST_FETCH:  if (src_ack)  nxt = ST_SETUP;
            ST_SETUP:  if (tm_zero)  nxt = ST_PULSE;
            ST_PULSE:  if (tm_zero)  nxt = ST_HOLD;
            ST_HOLD:   if (tm_zero)  nxt = over ? (last ? ST_SETTLE : ST_FETCH) : ST_VERIFY;
            ST_VERIFY: if (tm_zero) begin
                if (match)            nxt = long_m ? ST_SETUP : (last ? ST_SETTLE : ST_FETCH);
                else if (tries == lim) nxt = ST_FINISH;
                else                  nxt = ST_SETUP;
            end
            ST_SETTLE: if (tm_zero)  nxt = ST_CFETCH;
            ST_CFETCH: if (src_ack)  nxt = ST_CREAD;
            ST_CREAD:  if (tm_zero)  nxt = (!match || last) ? ST_FINISH : ST_CFETCH;
            default:                 nxt = ST_IDLE;
        endcase
    end

    // Length of the phase being entered; the timer loads it minus one.
    always_comb begin
        case (nxt)
            ST_VCC, ST_VPP, ST_SETUP, ST_SETTLE: len = TIM_W'(SETUP_CYC);
            ST_PULSE:  len = over ? TIM_W'(3 * LONG_CYC) * TIM_W'(tries)
                                  : (long_m ? TIM_W'(LONG_CYC) : TIM_W'(SHORT_CYC));
            ST_HOLD:   len = TIM_W'(HOLD_CYC);
            ST_VERIFY, ST_CREAD: len = TIM_W'(READ_CYC);
            default:   len = TIM_W'(1);
        endcase
        tm_val  = len - 1'b1;
        tm_load = (nxt != st);
    end

    // State, strobes, supply requests and per-word bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; word <= '0; tries <= '0; over <= 1'b0; long_m <= 1'b0;
            dev_ce_n <= 1'b1; dev_oe_n <= 1'b1; dev_pgm_n <= 1'b1; drive_en <= 1'b0;
            vcc_hi_req <= 1'b0; vpp_hi_req <= 1'b0;
            done <= 1'b0; pass <= 1'b0; fail <= 1'b0; fail_addr <= '0;
        end else begin
            st         <= nxt;
            dev_pgm_n  <= (nxt != ST_PULSE);
            dev_oe_n   <= !(nxt inside {ST_VERIFY, ST_CREAD});
            dev_ce_n   <= !(nxt inside {ST_SETUP, ST_PULSE, ST_HOLD, ST_VERIFY, ST_CREAD});
            drive_en   <= nxt inside {ST_SETUP, ST_PULSE, ST_HOLD};
            vcc_hi_req <= nxt inside {ST_VCC, ST_VPP, ST_FETCH, ST_SETUP, ST_PULSE, ST_HOLD, ST_VERIFY};
            vpp_hi_req <= nxt inside {ST_VPP, ST_FETCH, ST_SETUP, ST_PULSE, ST_HOLD, ST_VERIFY};
            if (st == ST_IDLE && start) begin
                long_m <= algo_long; done <= 1'b0; pass <= 1'b0; fail <= 1'b0;
            end
            if ((st == ST_FETCH || st == ST_CFETCH) && src_ack) begin
                word <= src_data; tries <= '0; over <= 1'b0;
            end
            if (st == ST_SETUP && nxt == ST_PULSE && !over) tries <= tries + 1'b1;
            if (st == ST_VERIFY && tm_zero && match && long_m) over <= 1'b1;
            if (nxt == ST_FINISH) begin
                done      <= 1'b1;
                pass      <= (st == ST_CREAD) && match;
                fail      <= !((st == ST_CREAD) && match);
                fail_addr <= dev_addr;
            end
        end
    end

    eps_timer #(.W(TIM_W)) u_tim (
        .clk(clk), .rst_n(rst_n), .load(tm_load), .val(tm_val), .zero(tm_zero)
    );

    eps_addr_walk #(.AW(ADDR_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .load(st == ST_IDLE && start), .first(start_addr), .final_a(end_addr),
        .rewind(st == ST_SETTLE && nxt == ST_CFETCH),
        .step((nxt == ST_FETCH && (st == ST_HOLD || st == ST_VERIFY)) ||
              (nxt == ST_CFETCH && st == ST_CREAD)),
        .addr(dev_addr), .last(last)
    );

    eps_bus_drv #(.DW(DATA_W)) u_bus (
        .en(drive_en), .dout(word), .din(din), .bus(dev_data)
    );
endmodule

// File: rtl/eps_checker.sv
// Property checker for eprom_prog_seq, attached by bind.
// Assumes windows are given in clock cycles; ages saturate at 16 bits.
module eps_checker #(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          pgm_n,
    input logic          vcc,
    input logic          vpp,
    input logic          drive_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] dout,
    input logic          done,
    input logic          pass,
    input logic          fail
);
    logic [15:0] setup_age, vpp_age, hold_age;

    // Track how long setup, programming supply and post-strobe drive have lasted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_age <= '0; vpp_age <= '0; hold_age <= '0;
        end else begin
            setup_age <= (drive_en && oe_n && pgm_n) ? ((setup_age != '1) ? setup_age + 1'b1 : setup_age) : '0;
            vpp_age   <= vpp ? ((vpp_age != '1) ? vpp_age + 1'b1 : vpp_age) : '0;
            hold_age  <= !pgm_n ? '0 : (drive_en ? ((hold_age != '1) ? hold_age + 1'b1 : hold_age) : '0);
        end
    end

    AST_VPP_NEEDS_VCC: assert property (@(posedge clk) disable iff (!rst_n) vpp |-> vcc); // R2
    AST_VPP_LEAD: assert property (@(posedge clk) disable iff (!rst_n) $fell(pgm_n) |-> vpp_age >= 16'(SETUP_CYC)); // R2
    AST_STROBE_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n) !pgm_n |-> (!ce_n && oe_n && drive_en && vpp)); // R3
    AST_SETUP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(pgm_n) |-> setup_age >= 16'(SETUP_CYC)); // R3
    AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!pgm_n && $past(!pgm_n)) |-> ($stable(addr) && $stable(dout))); // R3
    AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(drive_en) |-> hold_age >= 16'(HOLD_CYC)); // R3
    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> (!drive_en && !ce_n && pgm_n)); // R6
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) done |-> (pass ^ fail)); // R10
    AST_SUPPLY_DOWN_AT_END: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!vpp && !vcc && ce_n)); // R7
endmodule

bind eprom_prog_seq eps_checker #(
    .AW(ADDR_W), .DW(DATA_W), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(dev_ce_n), .oe_n(dev_oe_n), .pgm_n(dev_pgm_n),
    .vcc(vcc_hi_req), .vpp(vpp_hi_req), .drive_en(drive_en), .addr(dev_addr),
    .dout(word), .done(done), .pass(pass), .fail(fail)
);

// File: tb/sim_eprom_prog_seq.sv
// Bench: memory model that needs a set number of strobes per word, source
// server, and monitors; directed cases plus seeded random jobs.
module sim_eprom_prog_seq;
    localparam int MTS = 4, MTL = 3;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, algo_long = 1'b0;
    logic [15:0] start_addr = '0, end_addr = '0, src_data = '0, fail_addr, dev_addr;
    logic        src_req, src_ack = 1'b0, done, pass, fail;
    logic        dev_ce_n, dev_oe_n, dev_pgm_n, vcc_hi_req, vpp_hi_req;
    wire  [15:0] dev_data;

    logic [15:0] mem [16];
    logic [15:0] srcw [16];
    int          need [16], pulses [16], first_len [16], last_len [16];
    int          plen = 0, fetches = 0, cyc = 0, vcc_t = 0, min_lead = 1000000, clash = 0;
    logic        pvcc = 1'b0, pvpp = 1'b0, corrupt_en = 1'b0;
    int          corrupt_a = 0, n_chk = 0, n_bad = 0;
    bit          ended = 1'b0;

    always #5 clk = ~clk;

    eprom_prog_seq #(.CLK_HZ(1_000_000), .MAX_TRY_SHORT(MTS), .MAX_TRY_LONG(MTL)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .algo_long(algo_long),
        .start_addr(start_addr), .end_addr(end_addr), .src_req(src_req),
        .src_ack(src_ack), .src_data(src_data), .done(done), .pass(pass),
        .fail(fail), .fail_addr(fail_addr), .dev_addr(dev_addr), .dev_data(dev_data),
        .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n), .dev_pgm_n(dev_pgm_n),
        .vcc_hi_req(vcc_hi_req), .vpp_hi_req(vpp_hi_req)
    );

    assign dev_data = (!dev_ce_n && !dev_oe_n) ? mem[dev_addr[3:0]] : 'z;

    // Memory model, source server and supply monitor, all away from the active edge.
    always @(negedge clk) begin
        cyc++;
        src_ack  = src_req;
        src_data = srcw[dev_addr[3:0]];
        if (src_req) fetches++;
        if (!dev_ce_n && !dev_oe_n && dev_data !== mem[dev_addr[3:0]]) clash++;
        if (!dev_pgm_n) plen++;
        else if (plen != 0) begin
            pulses[dev_addr[3:0]]++;
            if (pulses[dev_addr[3:0]] == 1) first_len[dev_addr[3:0]] = plen;
            last_len[dev_addr[3:0]] = plen;
            if (pulses[dev_addr[3:0]] >= need[dev_addr[3:0]])
                mem[dev_addr[3:0]] = mem[dev_addr[3:0]] & dev_data;
            plen = 0;
        end
        if (vcc_hi_req && !pvcc) vcc_t = cyc;
        if (vpp_hi_req && !pvpp && (cyc - vcc_t) < min_lead) min_lead = cyc - vcc_t;
        if (!vpp_hi_req && pvpp && corrupt_en) mem[corrupt_a] = mem[corrupt_a] ^ 16'h0001;
        pvcc = vcc_hi_req; pvpp = vpp_hi_req;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic prep();
        for (int a = 0; a < 16; a++) begin
            mem[a] = 16'hFFFF; srcw[a] = 16'hFFFF; need[a] = 1;
            pulses[a] = 0; first_len[a] = 0; last_len[a] = 0;
        end
        corrupt_en = 1'b0; fetches = 0;
    endtask

    task automatic run_job(input int sa, input int ea, input bit lg);
        int w = 0;
        @(negedge clk);
        start_addr = 16'(sa); end_addr = 16'(ea); algo_long = lg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && w < 60000) begin
            @(negedge clk);
            w++;
        end
        chk(done, "R10 job finished (watchdog)", longint'(done), 1);
        chk(!vcc_hi_req && !vpp_hi_req && dev_ce_n, "R9 supplies low at end",
            longint'({vcc_hi_req, vpp_hi_req}), 0);
    endtask

    // Expected data after programming: cells only lose ones.
    function automatic logic [15:0] prog_word(input logic [15:0] old_w, input logic [15:0] s);
        return old_w & s;
    endfunction

    initial begin
        int n;
        void'($urandom(32'd1234));
        prep();
        repeat (4) @(negedge clk);
        chk(dev_ce_n && dev_oe_n && dev_pgm_n && !vcc_hi_req && !vpp_hi_req &&
            !src_req && !done && !pass && !fail && dev_data === 16'hzzzz,
            "R1 reset outputs", longint'({done, vcc_hi_req, vpp_hi_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dev_pgm_n && !vpp_hi_req, "R1 idle after reset", longint'(vpp_hi_req), 0);

        // Short algorithm, several words with varied strobe needs.
        prep();
        for (int a = 2; a <= 6; a++) begin
            srcw[a] = 16'($urandom) & 16'h7FFF; need[a] = 1 + int'($urandom % 3);
        end
        run_job(2, 6, 1'b0);
        chk(pass && !fail, "R9 short job passes", longint'(fail), 0);
        for (int a = 2; a <= 6; a++) begin
            chk(mem[a] == srcw[a], "R4 word written", mem[a], srcw[a]);
            chk(pulses[a] == need[a], "R4 strobes until verify", pulses[a], need[a]);
            chk(first_len[a] == 100 && last_len[a] == 100, "R4 short strobe length", last_len[a], 100);
        end
        chk(fetches == 10, "R8 fetch count both passes", fetches, 10);
        chk(min_lead >= 2, "R2 main supply leads", min_lead, 2);
        chk(clash == 0, "R6 no bus fight on reads", clash, 0);
        repeat (5) @(negedge clk);
        chk(done && pass, "R10 verdict held", longint'(done), 1);

        // Long algorithm with overprogram strobes.
        prep();
        srcw[8] = 16'h1234; need[8] = 1;
        srcw[9] = 16'h0F0F; need[9] = 2;
        run_job(8, 9, 1'b1);
        chk(pass, "R5 long job passes", longint'(pass), 1);
        for (int a = 8; a <= 9; a++) begin
            chk(pulses[a] == need[a] + 1, "R5 one extra strobe", pulses[a], need[a] + 1);
            chk(first_len[a] == 1000, "R5 long strobe length", first_len[a], 1000);
            chk(last_len[a] == 3000 * need[a], "R5 overprogram length", last_len[a], 3000 * need[a]);
        end

        // Cell already at 0 where the source wants 1: never verifies.
        prep();
        mem[3] = 16'hFF00; srcw[3] = 16'h0F0F;
        run_job(3, 3, 1'b0);
        chk(fail && !pass, "R11 unclearable word fails", longint'(fail), 1);
        chk(fail_addr == 16'd3, "R7 fail address", fail_addr, 3);
        chk(pulses[3] == MTS, "R7 short try limit", pulses[3], MTS);
        chk(mem[3] == prog_word(16'hFF00, 16'h0F0F), "R11 only clears", mem[3], prog_word(16'hFF00, 16'h0F0F));

        // Long algorithm try limit.
        prep();
        srcw[5] = 16'h00FF; need[5] = 9;
        run_job(5, 5, 1'b1);
        chk(fail && fail_addr == 16'd5, "R7 long abort address", fail_addr, 5);
        chk(pulses[5] == MTL && last_len[5] == 1000, "R7 long try limit, no overprogram", pulses[5], MTL);

        // Compare pass catches a word disturbed after the supplies drop.
        prep();
        for (int a = 10; a <= 12; a++) srcw[a] = 16'($urandom) & 16'hFFFE;
        corrupt_en = 1'b1; corrupt_a = 11;
        run_job(10, 12, 1'b0);
        chk(fail && fail_addr == 16'd11, "R9 compare mismatch address", fail_addr, 11);
        chk(fetches == 5, "R9 compare stops at first mismatch", fetches, 5);
        chk(mem[10] == srcw[10], "R9 earlier word intact", mem[10], srcw[10]);

        // Random short jobs, including single-word ranges.
        for (int j = 0; j < 4; j++) begin
            int sa;
            prep();
            sa = int'($urandom % 12); n = int'($urandom % 4);
            for (int a = sa; a <= sa + n; a++) begin
                srcw[a] = 16'($urandom) & 16'hBFFF; need[a] = 1 + int'($urandom % 3);
            end
            run_job(sa, sa + n, 1'b0);
            chk(pass, "R9 random job passes", longint'(pass), 1);
            chk(fetches == 2 * (n + 1), "R8 random fetch count", fetches, 2 * (n + 1));
            for (int a = sa; a <= sa + n; a++)
                chk(mem[a] == srcw[a] && pulses[a] == need[a], "R4 random word", mem[a], srcw[a]);
        end
        chk(clash == 0, "R6 no bus fight overall", clash, 0);

        ended = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (190000) @(negedge clk);
        if (!ended) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end
endmodule